// File: doc/BRIEF.md
# Multiply-divide occupancy interlock

This block sits beside the issue stage and decides, one request at a time, whether a multiply, a divide, a move into the hi/lo pair or a move out of it may issue this cycle. It keeps a few small down-counters for three things: the non-pipelined divider, the one-cycle multiplier hold that follows a 64-bit multiply, and the result latencies that a move out of hi/lo must wait for. The block does no arithmetic and holds no register data.

A request that issues is one presented with `req_valid` high while `stall` is low. The state advances only on issued requests. A divide runs in two parts. First comes a short lead-in that does not occupy the divider. Then it occupies the divider for 32 or 64 cycles. Because of this, a second divide may issue during the last few hold cycles of the first one, and its hold starts right where the first one ends. While any divide has a hi/lo write outstanding, the block blocks the other writers of hi/lo.

Top module: `mdi_interlock`

## Requirements
- R1: `req_op` encodes 0 = multiply, 1 = divide, 2 = move-to-hi/lo, 3 = move-from-hi/lo. `req_lo` picks lo (1) or hi (0) for a move-from. After reset, `stall`, `div_busy` and `hilo_wr_pend` are all low. `stall` is low whenever `req_valid` is low, and a request that is not valid changes no state.
- R2: A 64-bit multiply issued in cycle t stalls a multiply request in cycle t+1. A 32-bit multiply does not hold the multiplier.
- R3: After a multiply issued in cycle t, a move-from stalls until cycle t+3. The exception is a move-from of hi after a 64-bit multiply, which stalls until cycle t+4.
- R4: After a move-to issued in cycle t, multiply and divide requests stall until cycle t+4, and move-from requests stall until cycle t+3.
- R5: A divide issued in cycle t holds the divider (`div_busy` high) from cycle t+4 for 32 cycles (32-bit) or 64 cycles (64-bit). It does not hold the divider in cycles t+1 to t+3.
- R6: A divide request stalls while another divide is in its lead-in. It also stalls while more than 4 hold cycles of the current divide remain, counting the present cycle. When exactly 4 remain it is accepted, and its hold follows the previous hold with no gap.
- R7: `hilo_wr_pend` is high from cycle t+1 until cycle t+N+8 for a divide of N hold cycles issued in cycle t, and low from then on. While it is high, multiply and move-to requests stall.
- R8: A move-from stalls until the result latency (N+4 cycles) of the most recently issued divide has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | Request class (see R1) |
| req_wide | input | 1 | 1 = 64-bit operands, 0 = 32-bit |
| req_lo | input | 1 | Move-from target: 1 = lo, 0 = hi |
| stall | output | 1 | The presented request may not issue this cycle |
| div_busy | output | 1 | The divider is held this cycle |
| hilo_wr_pend | output | 1 | A divide's hi/lo write is still outstanding |

## Verification
The hardest case to reach is the hand-over between two divides. A second divide must be offered in exactly the cycle in which four hold cycles of the first remain, and the cycle before must be refused. To get there, the stimulus first issues a 32-bit divide through the move-to latency window. It then counts cycles from that issue and offers divides one cycle early and then on time. Finally it checks that `div_busy` stays high across the seam and that a move-from waits for the later, 64-bit divide rather than the earlier one.

// File: rtl/mdi_pkg.sv
package mdi_pkg;
   typedef enum logic [1:0] {
      OP_MUL  = 2'd0,
      OP_DIV  = 2'd1,
      OP_MTHL = 2'd2,
      OP_MFHL = 2'd3
   } mdi_op_e;
endpackage

// File: rtl/mdi_cdown.sv
module mdi_cdown #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt
);
   initial begin
      assert (W >= 1) else $error("mdi_cdown: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/mdi_div_track.sv
module mdi_div_track #(
   parameter int LEAD = 3,
   parameter int N32  = 32,
   parameter int N64  = 64,
   parameter int GAP  = 4,
   parameter int CW   = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          div_issue,
   input  logic          div_wide,
   output logic          lead_busy,
   output logic [CW-1:0] hold_left,
   output logic          res_wait,
   output logic          wr_pend,
   output logic          busy
);
   localparam int LW = $clog2(LEAD + 1);
   localparam logic [CW-1:0] HOLD_N = CW'(N32);
   localparam logic [CW-1:0] HOLD_W = CW'(N64);
   localparam logic [CW-1:0] RES_N  = CW'(N32 + LEAD);
   localparam logic [CW-1:0] RES_W  = CW'(N64 + LEAD);
   localparam logic [CW-1:0] PEND_N = CW'(N32 + LEAD + GAP);
   localparam logic [CW-1:0] PEND_W = CW'(N64 + LEAD + GAP);

   logic [LW-1:0] lead_cnt;
   logic          lead_wide;
   logic          hold_load;
   logic [CW-1:0] res_cnt;
   logic [CW-1:0] pend_cnt;

   // lead-in: cycles t+1..t+LEAD do not occupy the divider
   mdi_cdown #(.W(LW)) u_lead (
      .clk(clk), .rst_n(rst_n), .load(div_issue),
      .load_val(LW'(LEAD)), .cnt(lead_cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lead_wide <= 1'b0;
      else if (div_issue) lead_wide <= div_wide;
   end

   assign hold_load = (lead_cnt == LW'(1));

   mdi_cdown #(.W(CW)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(hold_load),
      .load_val(lead_wide ? HOLD_W : HOLD_N), .cnt(hold_left));

   mdi_cdown #(.W(CW)) u_res (
      .clk(clk), .rst_n(rst_n), .load(div_issue),
      .load_val(div_wide ? RES_W : RES_N), .cnt(res_cnt));

   mdi_cdown #(.W(CW)) u_pend (
      .clk(clk), .rst_n(rst_n), .load(div_issue),
      .load_val(div_wide ? PEND_W : PEND_N), .cnt(pend_cnt));

   assign lead_busy = (lead_cnt != '0);
   assign busy      = (hold_left != '0);
   assign res_wait  = (res_cnt != '0);
   assign wr_pend   = (pend_cnt != '0);

   // R5: the divider only becomes held at the end of a lead-in
   a_r5_hold_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(lead_busy));

   // R7: a held divider always has its hi/lo write outstanding
   a_r7_busy_in_pend: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> wr_pend);
endmodule

// File: rtl/mdi_mul_track.sv
module mdi_mul_track #(
   parameter int MUL_LAT   = 3,
   parameter int HI_EXTRA  = 1,
   parameter int MT_EXEC   = 4,
   parameter int MT_MF     = 3,
   parameter bit WIDE_HOLD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mul_issue,
   input  logic mul_wide,
   input  logic mt_issue,
   output logic mul_hold,
   output logic lo_wait,
   output logic hi_wait,
   output logic mt_blk_exec,
   output logic mt_blk_mf
);
   localparam int CW = $clog2(MUL_LAT + HI_EXTRA + MT_EXEC + 1);
   localparam logic [CW-1:0] LO_V  = CW'(MUL_LAT - 1);
   localparam logic [CW-1:0] HI_NV = CW'(MUL_LAT - 1);
   localparam logic [CW-1:0] HI_WV = CW'(MUL_LAT - 1 + HI_EXTRA);
   localparam logic [CW-1:0] MT_V  = CW'(MT_EXEC - 1);
   localparam logic [CW-1:0] MF_TH = CW'(MT_EXEC - MT_MF);

   logic [CW-1:0] lo_cnt;
   logic [CW-1:0] hi_cnt;
   logic [CW-1:0] mt_cnt;

   mdi_cdown #(.W(CW)) u_lo (
      .clk(clk), .rst_n(rst_n), .load(mul_issue),
      .load_val(LO_V), .cnt(lo_cnt));

   mdi_cdown #(.W(CW)) u_hi (
      .clk(clk), .rst_n(rst_n), .load(mul_issue),
      .load_val(mul_wide ? HI_WV : HI_NV), .cnt(hi_cnt));

   mdi_cdown #(.W(CW)) u_mt (
      .clk(clk), .rst_n(rst_n), .load(mt_issue),
      .load_val(MT_V), .cnt(mt_cnt));

   generate
      if (WIDE_HOLD) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mul_hold <= 1'b0;
            else        mul_hold <= mul_issue & mul_wide;
         end
      end else begin : g_nohold
         assign mul_hold = 1'b0;
      end
   endgenerate

   assign lo_wait     = (lo_cnt != '0);
   assign hi_wait     = (hi_cnt != '0);
   assign mt_blk_exec = (mt_cnt != '0);
   assign mt_blk_mf   = (mt_cnt > MF_TH);

   // R3: a fresh multiply always leaves the lo result outstanding next cycle
   a_r3_lo_after_mul: assert property (@(posedge clk) disable iff (!rst_n)
      mul_issue |=> lo_wait);
endmodule

// File: rtl/mdi_interlock.sv
module mdi_interlock #(
   parameter int DIV_LEAD  = 3,
   parameter int DIV_N32   = 32,
   parameter int DIV_N64   = 64,
   parameter int HILO_GAP  = 4,
   parameter int MUL_LAT   = 3,
   parameter int HI_EXTRA  = 1,
   parameter int MT_EXEC   = 4,
   parameter int MT_MF     = 3,
   parameter bit WIDE_HOLD = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_op,
   input  logic       req_wide,
   input  logic       req_lo,
   output logic       stall,
   output logic       div_busy,
   output logic       hilo_wr_pend
);
   import mdi_pkg::*;

   localparam int DCW = $clog2(DIV_N64 + DIV_LEAD + HILO_GAP + 2);
   localparam logic [DCW-1:0] HANDOVER = DCW'(DIV_LEAD + 1);

   initial begin
      assert (DIV_LEAD >= 1) else $error("mdi_interlock: DIV_LEAD below 1");
      assert (DIV_N32 >= 1 && DIV_N64 >= DIV_N32)
         else $error("mdi_interlock: divide hold lengths inconsistent");
      assert (MUL_LAT >= 1 && MT_EXEC >= 1) else $error("mdi_interlock: latency below 1");
      assert (MT_MF >= 1 && MT_MF <= MT_EXEC) else $error("mdi_interlock: MT_MF out of range");
   end

   mdi_op_e       op;
   logic          conflict;
   logic          issue;
   logic          mul_issue, div_issue, mt_issue;
   logic          lead_busy, res_wait, wr_pend, d_busy;
   logic [DCW-1:0] hold_left;
   logic          mul_hold, lo_wait, hi_wait, mt_blk_exec, mt_blk_mf;

   assign op = mdi_op_e'(req_op);

   mdi_div_track #(
      .LEAD(DIV_LEAD), .N32(DIV_N32), .N64(DIV_N64), .GAP(HILO_GAP), .CW(DCW)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .div_issue(div_issue), .div_wide(req_wide),
      .lead_busy(lead_busy), .hold_left(hold_left), .res_wait(res_wait),
      .wr_pend(wr_pend), .busy(d_busy));

   mdi_mul_track #(
      .MUL_LAT(MUL_LAT), .HI_EXTRA(HI_EXTRA), .MT_EXEC(MT_EXEC),
      .MT_MF(MT_MF), .WIDE_HOLD(WIDE_HOLD)
   ) u_mul (
      .clk(clk), .rst_n(rst_n), .mul_issue(mul_issue), .mul_wide(req_wide),
      .mt_issue(mt_issue), .mul_hold(mul_hold), .lo_wait(lo_wait),
      .hi_wait(hi_wait), .mt_blk_exec(mt_blk_exec), .mt_blk_mf(mt_blk_mf));

   always_comb begin
      conflict = 1'b0;
      unique case (op)
         OP_MUL:  conflict = mul_hold | mt_blk_exec | wr_pend;
         OP_DIV:  conflict = lead_busy | (hold_left > HANDOVER) | mt_blk_exec;
         OP_MTHL: conflict = wr_pend;
         OP_MFHL: conflict = mt_blk_mf | res_wait | (req_lo ? lo_wait : hi_wait);
         default: conflict = 1'b0;
      endcase
   end

   assign stall        = req_valid & conflict;
   assign issue        = req_valid & ~conflict;
   assign mul_issue    = issue & (op == OP_MUL);
   assign div_issue    = issue & (op == OP_DIV);
   assign mt_issue     = issue & (op == OP_MTHL);
   assign div_busy     = d_busy;
   assign hilo_wr_pend = wr_pend;

   // R1: no stall without a request
   a_r1_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !stall);

   // R2: a wide multiply keeps the next multiply out
   a_r2_wide_mul_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_issue && req_wide) |=> !(req_valid && op == OP_MUL && !stall));

   // R4: move-to followed at once by move-from is refused
   a_r4_mt_then_mf: assert property (@(posedge clk) disable iff (!rst_n)
      mt_issue |=> !(req_valid && op == OP_MFHL && !stall));

   // R6: two divides never issue in consecutive cycles
   a_r6_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      div_issue |=> !(req_valid && op == OP_DIV && !stall));
endmodule

// File: tb/mdi_interlock_test.sv
`timescale 1ns/1ps
module mdi_interlock_test;
   localparam bit [1:0] K_MUL = 2'd0, K_DIV = 2'd1, K_MT = 2'd2, K_MF = 2'd3;
   localparam int WATCH = 8 * 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic       req_wide = 1'b0;
   logic       req_lo = 1'b0;
   logic       stall, div_busy, hilo_wr_pend;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      int es;
      int eb;
      int ep;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   mdi_interlock uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_wide(req_wide), .req_lo(req_lo), .stall(stall),
      .div_busy(div_busy), .hilo_wr_pend(hilo_wr_pend));

   // driver: one request per cycle, expectation pushed for the same cycle
   task automatic step(input bit v, input bit [1:0] op, input bit w, input bit lo,
                       input int es, input int eb, input int ep, input string tag);
      exp_t e;
      @(negedge clk);
      #1;
      req_valid = v;
      req_op    = op;
      req_wide  = w;
      req_lo    = lo;
      e.es = es;
      e.eb = eb;
      e.ep = ep;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, K_MUL, 1'b0, 1'b0, -1, -1, -1, "");
   endtask

   task automatic cmp(input string what, input logic got, input int want, input string tag);
      if (want >= 0) begin
         checks++;
         if (got !== want[0]) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0d", tag, what, got, want);
         end
      end
   endtask

   // monitor: compares just before the next rising edge
   always begin
      @(negedge clk);
      #3;
      if (exp_q.size() > 0) begin
         exp_t  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         cmp("stall", stall, e.es, t);
         cmp("div_busy", div_busy, e.eb, t);
         cmp("hilo_wr_pend", hilo_wr_pend, e.ep, t);
      end
   end

   initial begin
      #(WATCH);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (R1): got no completion, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state and an invalid request
      step(0, K_DIV, 0, 0, 0, 0, 0, "R1 reset");
      step(0, K_MUL, 1, 0, 0, 0, 0, "R1 idle");

      // R2 / R3 multiplier segment
      step(1, K_MUL, 1, 0, 0, -1, -1, "R2 wide mul issues");
      step(1, K_MUL, 0, 0, 1, -1, -1, "R2 held after wide mul");
      step(1, K_MUL, 0, 0, 0, -1, -1, "R2 mul after hold");
      step(1, K_MUL, 0, 0, 0, -1, -1, "R2 narrow mul no hold");
      step(1, K_MF,  0, 1, 1, -1, -1, "R3 lo at +1");
      step(1, K_MF,  0, 1, 1, -1, -1, "R3 lo at +2");
      step(1, K_MF,  0, 1, 0, -1, -1, "R3 lo at +3");
      step(1, K_MUL, 1, 0, 0, -1, -1, "R3 wide mul");
      idle(2);
      step(1, K_MF,  0, 1, 0, -1, -1, "R3 wide lo at +3");
      step(1, K_MUL, 1, 0, 0, -1, -1, "R3 wide mul again");
      idle(2);
      step(1, K_MF,  0, 0, 1, -1, -1, "R3 wide hi at +3");
      step(1, K_MF,  0, 0, 0, -1, -1, "R3 wide hi at +4");
      idle(4);

      // R4 move-to latencies
      step(1, K_MT,  0, 0, 0, -1, -1, "R4 move-to");
      idle(2);
      step(1, K_MF,  0, 0, 0, -1, -1, "R4 move-from at +3");
      idle(3);
      step(1, K_MT,  0, 0, 0, -1, -1, "R4 move-to");
      step(1, K_MUL, 0, 0, 1, -1, -1, "R4 mul at +1");
      step(1, K_MF,  0, 0, 1, -1, -1, "R4 move-from at +2");
      step(1, K_DIV, 0, 0, 1, -1, -1, "R4 div at +3");
      step(1, K_DIV, 0, 0, 0, 0, 0, "R4 div at +4");      // divide A, k=0

      // divide segment, k counted from divide A
      step(1, K_DIV, 0, 0, 1, 0, 1, "R6 lead-in k1");
      step(1, K_MT,  0, 0, 1, 0, 1, "R7 move-to blocked k2");
      step(1, K_MUL, 0, 0, 1, 0, 1, "R5 R7 not yet held k3");
      step(0, K_MUL, 0, 0, 0, 1, 1, "R5 held at k4");
      step(1, K_MF,  0, 0, 1, 1, 1, "R8 result pending k5");
      idle(14);
      step(0, K_DIV, 0, 0, 0, 1, 1, "R1 invalid divide k20");
      idle(10);
      step(1, K_DIV, 0, 0, 1, 1, 1, "R6 five left k31");
      step(1, K_DIV, 1, 0, 0, 1, 1, "R6 four left k32");   // divide B, wide
      step(1, K_DIV, 0, 0, 1, 1, 1, "R6 B lead-in k33");
      idle(1);
      step(0, K_MUL, 0, 0, 0, 1, 1, "R5 last of A k35");
      step(1, K_MF,  0, 1, 1, 1, 1, "R6 R8 seam k36");
      idle(13);
      step(1, K_MUL, 0, 0, 1, 1, 1, "R7 mul during divide k50");
      idle(48);
      step(1, K_MF,  0, 0, 1, 1, 1, "R5 R8 k99");
      step(1, K_MF,  0, 0, 0, 0, 1, "R5 R8 k100");
      idle(2);
      step(1, K_MT,  0, 0, 1, 0, 1, "R7 pending k103");
      step(1, K_MT,  0, 0, 0, 0, 0, "R7 cleared k104");
      idle(3);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule